// File: doc/BRIEF.md
# Monitor Limit Alarm and Interrupt Unit

This block collects digitized monitor results for five channels: a temperature reading, the supply voltage and three external analog inputs. A converter delivers the results one at a time in the fixed cycle temperature, supply, monitor 1, monitor 2, monitor 3. Each result arrives with a valid strobe, a channel number and a 16-bit left-justified value. The unit stores the latest value of every channel and compares it against a high and a low limit that software programs. It keeps one high and one low alarm flag per channel, which follow the most recent comparison. It also keeps a sticky update bit per channel, which software can clear to find out when the next conversion lands.

Only the upper 12 bits of a value take part in a comparison. The temperature channel is a signed two's-complement number: whole degrees sit in the high byte and 1/256 degree in the low byte. The other channels are unsigned. A masked OR of all alarm flags forms an interrupt. The interrupt is merged into the first of two open-drain pass-through buffers, and each buffer has its own polarity inversion. The block does not drive the buffer pins. It produces pull-down enables, and the external pin reads high when the enable is 0.

Top module: `mon_alarm_unit`

## Requirements
- R1: A strobe with a channel number below the channel count stores the 16-bit value for that channel on the next clock edge. The value reads back at register address 00h plus the channel number, with temperature as channel 0, supply 1, monitor 1 as 2, monitor 2 as 3 and monitor 3 as 4.
- R2: Comparisons use only the upper 12 bits of the value and of each limit, so the low four bits never affect an alarm. A value equal to a limit in those 12 bits raises no alarm.
- R3: Channel 0 is compared as a signed two's-complement number, and every other channel is compared as unsigned.
- R4: When a result is stored, that channel's high flag becomes (value > high limit) and its low flag becomes (value < low limit). The flags keep those values until the next result for the channel arrives, so a flag clears again once the channel is back in range. The high limits are at 08h plus the channel number and the low limits at 10h plus the channel number, all read/write.
- R5: The update register at 18h holds one sticky bit per channel, at bit 7 minus the channel number. A stored result sets its bit. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R6: The alarm register at 19h is read-only, and writes to it have no effect. It holds the high flag at bit 15−2c and the low flag at bit 14−2c for channel c.
- R7: The interrupt, readable at bit 0 of 1Ch, is 1 when any channel whose enable bit is set has an alarm flag set. The enable mask is the low byte at 1Ah, with the bit for channel c at bit 7−c. A mask of zero keeps the interrupt at 0.
- R8: Buffer 1's level is interrupt OR (invert1 XOR input1), and buffer 2's level is invert2 XOR input2. The invert bits are bit 0 and bit 1 of 1Ah+1 = 1Bh. Each pull-down enable output is the inverse of its buffer's level.
- R9: Reset sets the following values:
  - stored values and limits: 0000h
  - update bits: 0
  - invert bits: 0
  - mask: F8h
  - alarm flags: all 0, except the supply low flag, which is 1 until the first supply result is stored.
- R10: A strobe whose channel number is at or above the channel count changes no value, flag or update bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result strobe |
| res_ch | input | 3 | Channel number of the result |
| res_data | input | 16 | Left-justified result value |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| buf1_in | input | 1 | Logic input of buffer 1 |
| buf2_in | input | 1 | Logic input of buffer 2 |
| buf1_pull_en | output | 1 | Pull-down enable of buffer 1 |
| buf2_pull_en | output | 1 | Pull-down enable of buffer 2 |

## Verification
The bench builds the unit with its default parameters: five channels, 16-bit values and 12 significant bits. With these values the signed comparator variant is used on channel 0 and the unsigned variant on the four others, and a four-bit ignored field sits under every comparison. That makes the following cases reachable:
- a negative temperature against a positive high limit, which an unsigned comparison would flag;
- values that differ from a limit only in the ignored nibble;
- supply readings above 8000h, where a signed comparison would give the wrong answer.

Channel numbers 5 to 7 fit in the 3-bit channel field but name no channel, so the out-of-range strobe can also be driven.

// File: rtl/mon_alarm_pkg.sv
package mon_alarm_pkg;
   localparam int TEMP_IDX   = 0;
   localparam int SUPPLY_IDX = 1;
   localparam int MASK_W     = 8;

   localparam logic [4:0] ADR_UPD   = 5'h18;
   localparam logic [4:0] ADR_ALARM = 5'h19;
   localparam logic [4:0] ADR_MASK  = 5'h1A;
   localparam logic [4:0] ADR_CFG   = 5'h1B;
   localparam logic [4:0] ADR_IRQ   = 5'h1C;

   localparam logic [MASK_W-1:0] MASK_RST = 8'hF8;

   typedef enum logic [1:0] {
      RGN_RESULT = 2'b00,
      RGN_HI     = 2'b01,
      RGN_LO     = 2'b10,
      RGN_CTRL   = 2'b11
   } reg_region_e;
endpackage

// File: rtl/mon_chan_slot.sv
module mon_chan_slot #(
   parameter int DATA_W     = 16,
   parameter int SIG_W      = 12,
   parameter bit SIGNED_CMP = 1'b0,
   parameter bit LO_RST     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store,
   input  logic [DATA_W-1:0] sample,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              upd_clr,
   output logic [DATA_W-1:0] result_q,
   output logic [DATA_W-1:0] hi_lim_q,
   output logic [DATA_W-1:0] lo_lim_q,
   output logic              hi_flag_q,
   output logic              lo_flag_q,
   output logic              upd_q
);
   localparam int MSB = DATA_W - 1;

   logic [SIG_W-1:0] s_sig, h_sig, l_sig;
   logic             above, below;

   assign s_sig = sample[MSB -: SIG_W];
   assign h_sig = hi_lim_q[MSB -: SIG_W];
   assign l_sig = lo_lim_q[MSB -: SIG_W];

   generate
      if (SIGNED_CMP) begin : g_signed
         assign above = $signed(s_sig) > $signed(h_sig);
         assign below = $signed(s_sig) < $signed(l_sig);
      end else begin : g_unsigned
         assign above = s_sig > h_sig;
         assign below = s_sig < l_sig;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q  <= '0;
         hi_lim_q  <= '0;
         lo_lim_q  <= '0;
         hi_flag_q <= 1'b0;
         lo_flag_q <= LO_RST;
         upd_q     <= 1'b0;
      end else begin
         if (store) begin
            result_q  <= sample;
            hi_flag_q <= above;
            lo_flag_q <= below;
         end
         if (hi_wr) hi_lim_q <= wdata;
         if (lo_wr) lo_lim_q <= wdata;
         if (store)        upd_q <= 1'b1;
         else if (upd_clr) upd_q <= 1'b0;
      end
   end

   // R1: a stored value appears on the result register one edge later
   assert_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> result_q == $past(sample));
   // R5: a store always leaves the update bit set
   assert_upd_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> upd_q);
   // R4: flags only move when a result is stored
   assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !store |=> ($stable(hi_flag_q) && $stable(lo_flag_q)));
endmodule

// File: rtl/mon_irq_merge.sv
module mon_irq_merge #(
   parameter int CHAN_N = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAN_N-1:0] hi_flags,
   input  logic [CHAN_N-1:0] lo_flags,
   input  logic [CHAN_N-1:0] en_raw,
   output logic              irq
);
   logic [CHAN_N-1:0] en;

   generate
      for (genvar i = 0; i < CHAN_N; i++) begin : g_en
         assign en[i] = en_raw[CHAN_N-1-i];
      end
   endgenerate

   assign irq = |((hi_flags | lo_flags) & en);

   // R7: an all-zero mask silences the interrupt
   assert_mask_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_raw == '0) |-> !irq);
   // R7: no flag set means no interrupt
   assert_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((hi_flags | lo_flags) == '0) |-> !irq);
endmodule

// File: rtl/mon_buf_drive.sv
module mon_buf_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic irq,
   input  logic in1,
   input  logic in2,
   input  logic inv1,
   input  logic inv2,
   output logic pull1_en,
   output logic pull2_en
);
   logic lvl1, lvl2;

   assign lvl1     = irq | (inv1 ^ in1);
   assign lvl2     = inv2 ^ in2;
   assign pull1_en = ~lvl1;
   assign pull2_en = ~lvl2;

   // R8: a pending interrupt always releases buffer 1
   assert_irq_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !pull1_en);
   // R8: buffer 2 is independent of the interrupt
   assert_buf2_indep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(in2) && $stable(inv2)) |-> $stable(pull2_en));
endmodule

// File: rtl/mon_alarm_unit.sv
module mon_alarm_unit
   import mon_alarm_pkg::*;
#(
   parameter int CHAN_N = 5,
   parameter int DATA_W = 16,
   parameter int SIG_W  = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      res_valid,
   input  logic [$clog2(CHAN_N)-1:0] res_ch,
   input  logic [DATA_W-1:0]         res_data,
   input  logic [4:0]                reg_addr,
   input  logic                      reg_wr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   input  logic                      buf1_in,
   input  logic                      buf2_in,
   output logic                      buf1_pull_en,
   output logic                      buf2_pull_en
);
   localparam int CH_W = $clog2(CHAN_N);

   generate
      if (CHAN_N < 2 || CHAN_N > MASK_W) begin : g_bad_chan
         $error("mon_alarm_unit: CHAN_N must be 2..8");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("mon_alarm_unit: DATA_W must be at least 16");
      end
      if (SIG_W < 1 || SIG_W > DATA_W) begin : g_bad_sig
         $error("mon_alarm_unit: SIG_W must be 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] result_q [CHAN_N];
   logic [DATA_W-1:0] hi_lim_q [CHAN_N];
   logic [DATA_W-1:0] lo_lim_q [CHAN_N];
   logic [CHAN_N-1:0] hi_flag, lo_flag, upd, store, hi_wr, lo_wr, upd_clr;
   logic [MASK_W-1:0] mask_q;
   logic              inv1_q, inv2_q, irq;
   logic [DATA_W-1:0] alarm_vec, upd_vec;
   reg_region_e       rgn;

   assign rgn = reg_region_e'(reg_addr[4:3]);

   generate
      for (genvar i = 0; i < CHAN_N; i++) begin : g_slot
         assign store[i]   = res_valid && (res_ch == CH_W'(i));
         assign hi_wr[i]   = reg_wr && (rgn == RGN_HI) && (reg_addr[2:0] == 3'(i));
         assign lo_wr[i]   = reg_wr && (rgn == RGN_LO) && (reg_addr[2:0] == 3'(i));
         assign upd_clr[i] = reg_wr && (reg_addr == ADR_UPD) && !reg_wdata[MASK_W-1-i];

         mon_chan_slot #(
            .DATA_W     (DATA_W),
            .SIG_W      (SIG_W),
            .SIGNED_CMP (i == TEMP_IDX),
            .LO_RST     (i == SUPPLY_IDX)
         ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .store     (store[i]),
            .sample    (res_data),
            .hi_wr     (hi_wr[i]),
            .lo_wr     (lo_wr[i]),
            .wdata     (reg_wdata),
            .upd_clr   (upd_clr[i]),
            .result_q  (result_q[i]),
            .hi_lim_q  (hi_lim_q[i]),
            .lo_lim_q  (lo_lim_q[i]),
            .hi_flag_q (hi_flag[i]),
            .lo_flag_q (lo_flag[i]),
            .upd_q     (upd[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= MASK_RST;
         inv1_q <= 1'b0;
         inv2_q <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == ADR_MASK) mask_q <= reg_wdata[MASK_W-1:0];
         if (reg_addr == ADR_CFG) begin
            inv1_q <= reg_wdata[0];
            inv2_q <= reg_wdata[1];
         end
      end
   end

   always_comb begin
      alarm_vec = '0;
      upd_vec   = '0;
      for (int i = 0; i < CHAN_N; i++) begin
         alarm_vec[15-2*i]     = hi_flag[i];
         alarm_vec[14-2*i]     = lo_flag[i];
         upd_vec[MASK_W-1-i]   = upd[i];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (rgn)
         RGN_RESULT, RGN_HI, RGN_LO: begin
            for (int i = 0; i < CHAN_N; i++) begin
               if (reg_addr[2:0] == 3'(i)) begin
                  if (rgn == RGN_RESULT)  reg_rdata = result_q[i];
                  else if (rgn == RGN_HI) reg_rdata = hi_lim_q[i];
                  else                    reg_rdata = lo_lim_q[i];
               end
            end
         end
         default: begin
            if (reg_addr == ADR_UPD)        reg_rdata = upd_vec;
            else if (reg_addr == ADR_ALARM) reg_rdata = alarm_vec;
            else if (reg_addr == ADR_MASK)  reg_rdata[MASK_W-1:0] = mask_q;
            else if (reg_addr == ADR_CFG)   reg_rdata[1:0] = {inv2_q, inv1_q};
            else if (reg_addr == ADR_IRQ)   reg_rdata[0] = irq;
         end
      endcase
   end

   mon_irq_merge #(.CHAN_N(CHAN_N)) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_flags (hi_flag),
      .lo_flags (lo_flag),
      .en_raw   (mask_q[MASK_W-1 -: CHAN_N]),
      .irq      (irq)
   );

   mon_buf_drive i_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq      (irq),
      .in1      (buf1_in),
      .in2      (buf2_in),
      .inv1     (inv1_q),
      .inv2     (inv2_q),
      .pull1_en (buf1_pull_en),
      .pull2_en (buf2_pull_en)
   );

   // R6: writes to the alarm register leave the flags as they were
   assert_alarm_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_ALARM && !res_valid) |=> $stable(alarm_vec));
   // R10: out-of-range channel strobes touch nothing
   assert_bad_ch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && int'(res_ch) >= CHAN_N && !reg_wr) |=>
         ($stable(upd_vec) && $stable(alarm_vec)));
endmodule

// File: tb/test_mon_alarm_unit.sv
module test_mon_alarm_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [2:0]  res_ch = '0;
   logic [15:0] res_data = '0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        buf1_in = 1'b0, buf2_in = 1'b0;
   logic        buf1_pull_en, buf2_pull_en;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mon_alarm_unit i_mon_alarm_unit (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
      .res_data(res_data), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf1_in(buf1_in),
      .buf2_in(buf2_in), .buf1_pull_en(buf1_pull_en), .buf2_pull_en(buf2_pull_en)
   );

   // {channel, value, expected high flag, expected low flag}
   localparam logic [20:0] VEC [NVEC] = '{
      {3'd0, 16'h1000, 1'b0, 1'b0},
      {3'd1, 16'h9000, 1'b0, 1'b0},
      {3'd2, 16'h800F, 1'b0, 1'b0},
      {3'd3, 16'hFFFF, 1'b0, 1'b0},
      {3'd4, 16'h4000, 1'b0, 1'b0},
      {3'd0, 16'hF000, 1'b0, 1'b1},
      {3'd1, 16'hC010, 1'b1, 1'b0},
      {3'd2, 16'h0FF0, 1'b0, 1'b1},
      {3'd3, 16'h0005, 1'b0, 1'b0},
      {3'd4, 16'h3FF0, 1'b0, 1'b1},
      {3'd0, 16'h1910, 1'b1, 1'b0},
      {3'd1, 16'h7FFF, 1'b0, 1'b1},
      {3'd2, 16'h8010, 1'b1, 1'b0},
      {3'd3, 16'h1234, 1'b0, 1'b0},
      {3'd4, 16'h4010, 1'b1, 1'b0},
      {3'd0, 16'h0000, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic push(input logic [2:0] ch, input logic [15:0] v);
      @(negedge clk);
      res_valid = 1'b1; res_ch = ch; res_data = v;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R9)
      rd(5'h01, d); check("R9 supply result", d, 16'h0000);
      rd(5'h08, d); check("R9 temp high limit", d, 16'h0000);
      rd(5'h12, d); check("R9 monitor1 low limit", d, 16'h0000);
      rd(5'h18, d); check("R9 update bits", d, 16'h0000);
      rd(5'h19, d); check("R9 alarm flags supply low", d, 16'h1000);
      rd(5'h1A, d); check("R9 mask", d, 16'h00F8);
      rd(5'h1B, d); check("R9 invert bits", d, 16'h0000);
      check("R9 buffer1 released by irq", buf1_pull_en, 1'b0);
      check("R9 buffer2 pulled low", buf2_pull_en, 1'b1);

      // limits
      wr(5'h08, 16'h1900); wr(5'h10, 16'hF600);
      wr(5'h09, 16'hC000); wr(5'h11, 16'h8000);
      wr(5'h0A, 16'h8000); wr(5'h12, 16'h1000);
      wr(5'h0B, 16'hFFF0); wr(5'h13, 16'h0000);
      wr(5'h0C, 16'h4000); wr(5'h14, 16'h4000);
      rd(5'h09, d); check("R4 limit readback", d, 16'hC000);

      // vector table: R1 R2 R3 R4 R5
      for (int k = 0; k < NVEC; k++) begin
         logic [2:0]  ch;
         logic [15:0] v;
         logic [1:0]  fl;
         ch = VEC[k][20:18];
         v  = VEC[k][17:2];
         fl = VEC[k][1:0];
         push(ch, v);
         rd({2'b00, ch}, d); check("R1 stored value", d, v);
         rd(5'h19, d);
         check("R2 R3 R4 alarm pair", {d[15-2*ch], d[14-2*ch]}, fl);
         rd(5'h18, d); check("R5 update bit set", d[7-ch], 1'b1);
      end

      // R5 clear and write-one
      wr(5'h18, 16'h0000);
      rd(5'h18, d); check("R5 clear by zero", d, 16'h0000);
      wr(5'h18, 16'hFFFF);
      rd(5'h18, d); check("R5 write one no effect", d, 16'h0000);
      push(3'd1, 16'h9000);
      rd(5'h18, d); check("R5 only supply bit", d, 16'h0040);
      rd(5'h19, d); check("R4 supply low clears", d, 16'h0880);

      // R6
      wr(5'h19, 16'h0000);
      rd(5'h19, d); check("R6 alarm write ignored", d, 16'h0880);
      wr(5'h19, 16'hFFFF);
      rd(5'h19, d); check("R6 alarm write ones ignored", d, 16'h0880);

      // R7
      wr(5'h1A, 16'h0008);
      rd(5'h1C, d); check("R7 monitor3 enabled", d, 16'h0001);
      wr(5'h1A, 16'h0010);
      rd(5'h1C, d); check("R7 monitor2 only no alarm", d, 16'h0000);
      check("R7 buffer1 pulled without irq", buf1_pull_en, 1'b1);
      wr(5'h1A, 16'h0000);
      rd(5'h1C, d); check("R7 zero mask", d, 16'h0000);

      // R8
      buf1_in = 1'b1; #1;
      check("R8 in1 passes", buf1_pull_en, 1'b0);
      wr(5'h1B, 16'h0001); #1;
      check("R8 inverted in1 high", buf1_pull_en, 1'b1);
      buf1_in = 1'b0; #1;
      check("R8 inverted in1 low", buf1_pull_en, 1'b0);
      buf1_in = 1'b1;
      wr(5'h1A, 16'h0020); #1;
      check("R8 irq overrides inverted input", buf1_pull_en, 1'b0);
      check("R8 buffer2 no inversion in2 low", buf2_pull_en, 1'b1);
      wr(5'h1B, 16'h0002); #1;
      check("R8 buffer2 inverted in2 low", buf2_pull_en, 1'b0);
      buf2_in = 1'b1; #1;
      check("R8 buffer2 inverted in2 high", buf2_pull_en, 1'b1);

      // R10
      wr(5'h18, 16'h0000);
      push(3'd5, 16'hABCD);
      push(3'd7, 16'h0000);
      rd(5'h18, d); check("R10 update untouched", d, 16'h0000);
      rd(5'h19, d); check("R10 flags untouched", d, 16'h0880);
      rd(5'h04, d); check("R10 monitor3 value untouched", d, 16'h4010);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule